// File: doc/BRIEF.md
# Buffered Byte-Serial Transceiver with Control Register

This block moves bytes over a four-wire synchronous serial link. It can run either as the clock source (master) or as a follower (slave), with the role chosen by a control register on a small processor bus. A transmit holding register and a receive holding register sit on either side of a single shift register. Software can therefore queue the next outgoing byte while the current one is still being shifted, and it can collect the last incoming byte while the next one arrives.

All four combinations of clock idle level and sampling phase are supported. As master, the serial clock comes from a fixed divider of the system clock. As slave, the incoming clock, data and select lines pass through synchronisers and are sampled in the system clock domain. A receive-full flag, an overrun flag and a transmit-empty flag are visible on the bus. Each of the two "ready" flags can raise the interrupt line if its own enable bit is set.

When the slave samples on the leading edge (phase 0), a falling select line starts each byte: the first outgoing bit is presented before any clock edge. Every byte needs its own select-low period.

Top module: `spi_dbuf`

## Requirements
- R1: The control register sits at bus address 0. Its bits, from 7 down to 0, are: receive-interrupt enable, reserved, master select, clock idle level, clock phase, stored-only wired-OR flag, enable, transmit-interrupt enable. It resets to 0x28. The reserved bit 6 always reads 0.
- R2: Master select set to 1 makes the block master: it drives `sck_o` and `mosi_o` (`sck_oe` and `mosi_oe` high while enabled). Master select at 0 makes it a slave that is clocked by `sck_i`.
- R3: While no transfer is in progress, `sck_o` rests at the level of the clock idle bit (bit 4).
- R4: Data moves most significant bit first in both directions. In all four idle-level/phase combinations, the master sends the written byte and receives the slave's byte intact. Phase 0 samples on the leading edge; phase 1 samples on the trailing edge.
- R5: Status at address 1 has bit 0 = receive full, bit 1 = overrun, bit 2 = transmit empty, and bits 7..3 read 0. Receive full sets when a finished byte enters the receive register, which is read at address 2. A read at address 2 clears receive full and overrun.
- R6: `irq` is high exactly when (control bit 7 and receive full) or (control bit 0 and transmit empty).
- R7: If a byte completes while receive full is still set, overrun sets and the receive register holds the newer byte.
- R8: A write to address 2 while enabled fills the transmit register and clears transmit empty. Transmit empty sets again when that byte moves into the shift register. After reset it is 1.
- R9: A master transfer starts only when a byte is pending, the enable bit (bit 1) is set and master mode is selected. A write to address 2 while the enable bit is 0 is dropped.
- R10: Once a transfer has started, the shift register takes no new byte. A byte written meanwhile waits and is sent in the next transfer.
- R11: In slave mode with phase 0, a falling `ss_n_i` starts the transfer and the most significant bit appears on `miso_o` (with `miso_oe` high) before the first clock edge. Clock pulses after a completed byte are ignored until `ss_n_i` has risen and fallen again.
- R12: With the enable bit at 0, the shift engine is idle: `sck_o` rests at the idle level, and `sck_oe`, `mosi_oe` and `miso_oe` are low.
- R13: In slave mode with phase 1, each byte starts at the first leading clock edge while `ss_n_i` is low. Consecutive bytes may share one select-low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data from master (slave) |
| mosi_o | output | 1 | Serial data to slave (master) |
| mosi_oe | output | 1 | Master data output enable |
| miso_i | input | 1 | Serial data from slave (master) |
| miso_o | output | 1 | Serial data to master (slave) |
| miso_oe | output | 1 | Slave data output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
A wrong edge selection or bit counter shows up as a shifted or bit-reversed byte: on `mosi_o` within the same transfer, and in the receive register once the flag rises. A wrong flag update shows up in the status byte on the next bus read and in `irq` in the very next cycle. A shift register that reloads during a transfer corrupts the bits seen on `miso_o` or `mosi_o` before the current byte ends. A missing slave-select lock shows up as a byte received without a fresh select edge.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic rxie;
        logic rsvd;
        logic master;
        logic cpol;
        logic cpha;
        logic wom;
        logic en;
        logic txie;
    } ctrl_t;

    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'b0010_1000;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic [4:0] zero;
        logic       tx_empty;
        logic       overrun;
        logic       rx_full;
    } stat_t;

    // bus value to control fields, reserved position forced low
    function automatic ctrl_t ctrl_from_bus(input logic [BYTE_W-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/spi_dbuf_regs.sv
module spi_dbuf_regs
    import spi_dbuf_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          load,
    input  logic          done,
    input  logic [BW-1:0] rx_byte,
    output ctrl_t         ctrl,
    output logic [BW-1:0] tx_byte,
    output logic          tx_pending,
    output logic          irq
);

    logic          tx_empty;
    logic          rx_full;
    logic          overrun;
    logic [BW-1:0] rx_q;
    logic          wr_ctrl;
    logic          wr_data;
    logic          rd_data;
    stat_t         stat;

    assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_CTRL);
    assign wr_data = bus_en && bus_we && (bus_addr == ADDR_DATA) && ctrl.en;
    assign rd_data = bus_en && !bus_we && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= ctrl_t'(CTRL_RESET);
            tx_byte  <= '0;
            tx_empty <= 1'b1;
            rx_q     <= '0;
            rx_full  <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl <= ctrl_from_bus(bus_wdata);
            if (load)
                tx_empty <= 1'b1;
            if (wr_data) begin
                tx_byte  <= bus_wdata;
                tx_empty <= 1'b0;
            end
            if (rd_data) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (done) begin
                rx_q    <= rx_byte;
                rx_full <= 1'b1;
                if (rx_full && !rd_data)
                    overrun <= 1'b1;
            end
        end
    end

    always_comb begin
        stat          = '0;
        stat.tx_empty = tx_empty;
        stat.overrun  = overrun;
        stat.rx_full  = rx_full;
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_STAT: bus_rdata = stat;
            ADDR_DATA: bus_rdata = rx_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign tx_pending = !tx_empty;
    assign irq = (ctrl.rxie && rx_full) || (ctrl.txie && tx_empty);

    // R7: overrun only ever accompanies a full receive register
    a_r7_overrun_with_full: assert property (@(posedge clk) disable iff (rst)
        overrun |-> rx_full);

    // R5: a finished byte always leaves the full flag set
    a_r5_done_sets_full: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full);

    // R8: moving the byte into the shifter empties the holding register
    a_r8_load_empties: assert property (@(posedge clk) disable iff (rst)
        (load && !wr_data) |=> tx_empty);

    // R9: data writes while disabled leave the transmit flag untouched
    a_r9_disabled_write: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr == ADDR_DATA && !ctrl.en) |=> $stable(tx_empty));

endmodule

// File: rtl/spi_dbuf_clkgen.sv
module spi_dbuf_clkgen #(
    parameter int DIV_HALF = 2,
    parameter int EDGES    = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic lead,
    output logic trail,
    output logic last,
    output logic ph_o
);

    localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int EW = $clog2(EDGES);

    logic [HW-1:0] hcnt;
    logic [EW-1:0] ecnt;
    logic          ph;
    logic          tick;

    assign tick  = run && (hcnt == HW'(DIV_HALF - 1));
    assign lead  = tick && !ecnt[0];
    assign trail = tick && ecnt[0];
    assign last  = trail && (ecnt == EW'(EDGES - 1));
    assign ph_o  = ph && run;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
            ecnt <= '0;
            ph   <= 1'b0;
        end else if (tick) begin
            hcnt <= '0;
            ecnt <= ecnt + 1'b1;
            ph   <= ~ph;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R3: the divider is back at rest whenever no master transfer runs
    a_r3_rest_phase: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ecnt == '0 && !ph));

    // R4: a leading tick always moves the clock away from its idle level
    a_r4_lead_moves: assert property (@(posedge clk) disable iff (rst)
        lead |=> ph);

endmodule

// File: rtl/spi_dbuf_sync.sv
module spi_dbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cpol,
    input  logic sck_i,
    input  logic mosi_i,
    input  logic ss_n_i,
    output logic s_lead,
    output logic s_trail,
    output logic s_mosi,
    output logic s_ss_low,
    output logic s_ss_fall
);

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] mosi_p;
    logic [STAGES-1:0] ss_p;
    logic              sck_d;
    logic              ss_d;
    logic              sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p  <= '0;
            mosi_p <= '0;
            ss_p   <= '1;
            sck_d  <= 1'b0;
            ss_d   <= 1'b1;
        end else begin
            sck_p  <= {sck_p[STAGES-2:0], sck_i};
            mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
            ss_p   <= {ss_p[STAGES-2:0], ss_n_i};
            sck_d  <= sck_p[STAGES-1];
            ss_d   <= ss_p[STAGES-1];
        end
    end

    assign sck_s     = sck_p[STAGES-1];
    assign s_lead    = (sck_s != cpol) && (sck_d == cpol);
    assign s_trail   = (sck_s == cpol) && (sck_d != cpol);
    assign s_mosi    = mosi_p[STAGES-1];
    assign s_ss_low  = !ss_p[STAGES-1];
    assign s_ss_fall = ss_d && !ss_p[STAGES-1];

    // R11: one select fall yields a single start pulse
    a_r11_single_fall: assert property (@(posedge clk) disable iff (rst)
        s_ss_fall |=> !s_ss_fall);

endmodule

// File: rtl/spi_dbuf_shift.sv
module spi_dbuf_shift #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          master,
    input  logic          cpha,
    input  logic [BW-1:0] tx_byte,
    input  logic          tx_pending,
    input  logic          m_lead,
    input  logic          m_trail,
    input  logic          m_last,
    input  logic          s_lead,
    input  logic          s_trail,
    input  logic          s_mosi,
    input  logic          s_ss_low,
    input  logic          s_ss_fall,
    input  logic          miso_i,
    output logic          busy,
    output logic          load,
    output logic          done,
    output logic [BW-1:0] rx_byte,
    output logic          dout
);

    localparam int CW = $clog2(BW + 1);

    logic [BW-1:0] tx_sr;
    logic [BW-1:0] rx_sr;
    logic [CW-1:0] cnt;
    logic          lead;
    logic          trail;
    logic          din;
    logic          sample_e;
    logic          shift_e;
    logic          abort;
    logic          start;
    logic          fin;

    always_comb begin
        lead     = master ? m_lead  : (s_lead  && s_ss_low);
        trail    = master ? m_trail : (s_trail && s_ss_low);
        din      = master ? miso_i  : s_mosi;
        sample_e = cpha ? trail : lead;
        shift_e  = cpha ? lead  : trail;
        abort    = !en || (!master && !s_ss_low);
        start    = en && !busy &&
                   (master ? tx_pending : (cpha ? (s_lead && s_ss_low) : s_ss_fall));
        rx_byte  = {rx_sr[BW-2:0], din};
        done     = busy && !abort && sample_e && (cnt == CW'(BW - 1));
        fin      = master ? m_last : done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt   <= '0;
            tx_sr <= tx_byte;
        end else if (busy) begin
            if (sample_e) begin
                rx_sr <= rx_byte;
                cnt   <= cnt + 1'b1;
            end
            if (shift_e && !(cpha && cnt == '0))
                tx_sr <= {tx_sr[BW-2:0], 1'b0};
            if (fin)
                busy <= 1'b0;
        end
    end

    assign load = start;
    assign dout = tx_sr[BW-1];

    // R4: never more samples than bits in a byte
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(BW));

    // R9: a transfer only begins while the block is enabled
    a_r9_start_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(en));

    // R11: a slave goes idle after its last bit and waits for a new start
    a_r11_slave_idle_after_byte: assert property (@(posedge clk) disable iff (rst)
        (done && !master) |=> !busy);

endmodule

// File: rtl/spi_dbuf.sv
module spi_dbuf
    import spi_dbuf_pkg::*;
#(
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq,
    input  logic        sck_i,
    output logic        sck_o,
    output logic        sck_oe,
    input  logic        mosi_i,
    output logic        mosi_o,
    output logic        mosi_oe,
    input  logic        miso_i,
    output logic        miso_o,
    output logic        miso_oe,
    input  logic        ss_n_i
);

    localparam int EDGES = 2 * BYTE_W;

    ctrl_t             ctrl;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] rx_byte;
    logic              tx_pending;
    logic              load;
    logic              done;
    logic              busy;
    logic              run;
    logic              m_lead, m_trail, m_last, ph;
    logic              s_lead, s_trail, s_mosi, s_ss_low, s_ss_fall;
    logic              dout;

    spi_dbuf_regs #(.BW(BYTE_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .load(load), .done(done), .rx_byte(rx_byte),
        .ctrl(ctrl), .tx_byte(tx_byte), .tx_pending(tx_pending), .irq(irq)
    );

    assign run = busy && ctrl.master;

    spi_dbuf_clkgen #(.DIV_HALF(DIV_HALF), .EDGES(EDGES)) u_clkgen (
        .clk(clk), .rst(rst), .run(run),
        .lead(m_lead), .trail(m_trail), .last(m_last), .ph_o(ph)
    );

    spi_dbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cpol(ctrl.cpol),
        .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
        .s_lead(s_lead), .s_trail(s_trail), .s_mosi(s_mosi),
        .s_ss_low(s_ss_low), .s_ss_fall(s_ss_fall)
    );

    spi_dbuf_shift #(.BW(BYTE_W)) u_shift (
        .clk(clk), .rst(rst),
        .en(ctrl.en), .master(ctrl.master), .cpha(ctrl.cpha),
        .tx_byte(tx_byte), .tx_pending(tx_pending),
        .m_lead(m_lead), .m_trail(m_trail), .m_last(m_last),
        .s_lead(s_lead), .s_trail(s_trail), .s_mosi(s_mosi),
        .s_ss_low(s_ss_low), .s_ss_fall(s_ss_fall),
        .miso_i(miso_i),
        .busy(busy), .load(load), .done(done), .rx_byte(rx_byte), .dout(dout)
    );

    assign sck_o   = ctrl.cpol ^ ph;
    assign sck_oe  = ctrl.en && ctrl.master;
    assign mosi_oe = ctrl.en && ctrl.master;
    assign mosi_o  = dout;
    assign miso_oe = ctrl.en && !ctrl.master && s_ss_low;
    assign miso_o  = dout;

    // R12: with the block disabled no pin is driven
    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !(sck_oe || mosi_oe || miso_oe));

endmodule

// File: tb/test_spi_dbuf.sv
`timescale 1ns/1ps
module test_spi_dbuf;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_en, bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       irq;
    logic       sck_i, sck_o, sck_oe;
    logic       mosi_i, mosi_o, mosi_oe;
    logic       miso_i, miso_o, miso_oe;
    logic       ss_n_i;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    localparam int H = 8;

    always #2.5 clk = ~clk;

    spi_dbuf i_spi_dbuf (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i)
    );

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    function automatic logic [7:0] cw(input logic rxie, master, cpol, cpha, en, txie);
        return {rxie, 1'b0, master, cpol, cpha, 1'b0, en, txie};
    endfunction

    task automatic wedge(input logic cpol, input logic lead);
        if (cpol ^ lead) @(posedge sck_o);
        else             @(negedge sck_o);
    endtask

    // bench plays the slave for a master transfer
    task automatic smodel(input logic cpol, cpha, input logic [7:0] stx, output logic [7:0] cap);
        cap = '0;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                miso_i = stx[i];
                wedge(cpol, 1'b1);
                cap[i] = mosi_o;
                wedge(cpol, 1'b0);
            end else begin
                wedge(cpol, 1'b1);
                miso_i = stx[i];
                wedge(cpol, 1'b0);
                cap[i] = mosi_o;
            end
        end
    endtask

    // bench plays the master for a slave transfer (select handled outside)
    task automatic mframe(input logic cpol, cpha, input logic [7:0] b, output logic [7:0] cap);
        cap = '0;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = b[i];
                wc(H);
                cap[i] = miso_o;
                sck_i = ~cpol;
                wc(H);
                sck_i = cpol;
            end else begin
                wc(H);
                sck_i = ~cpol;
                mosi_i = b[i];
                wc(H);
                cap[i] = miso_o;
                sck_i = cpol;
            end
        end
        wc(H);
    endtask

    task automatic mxfer(input logic cpol, cpha, input logic [7:0] mtx, stx);
        logic [7:0] cap;
        miso_i = stx[7];
        fork
            smodel(cpol, cpha, stx, cap);
            bw(2'd2, mtx);
        join
        wc(6);
        chk($sformatf("R4 mosi byte mode %0d%0d", cpol, cpha), cap, mtx);
        chk("R3 clock idle after transfer", {7'd0, sck_o}, {7'd0, cpol});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, c1, c2, mt, st;
        rst = 1'b1; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        sck_i = 0; mosi_i = 0; miso_i = 0; ss_n_i = 1'b1;
        wc(4);
        rst = 1'b0;
        wc(2);

        // reset state
        br(2'd0, d); chk("R1 control reset value", d, 8'h28);
        br(2'd1, d); chk("R8 status after reset", d, 8'h04);
        chk("R6 irq after reset", {7'd0, irq}, 8'h00);
        chk("R12 sck_oe while disabled", {7'd0, sck_oe}, 8'h00);
        chk("R3 sck idle after reset", {7'd0, sck_o}, 8'h00);

        // R1 reserved bit, R6 transmit interrupt
        bw(2'd0, 8'hFF);
        br(2'd0, d); chk("R1 reserved bit reads zero", d, 8'hBF);
        chk("R6 irq from tx empty", {7'd0, irq}, 8'h01);
        chk("R2 master drives clock", {6'd0, sck_oe, mosi_oe}, 8'h03);
        bw(2'd0, 8'h28);

        // R4 sweep over all modes and a set of byte patterns
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 4; k++) begin
                mt = 8'(k * 8'h5B + 8'hA1 + m * 8'h13);
                st = ~mt ^ 8'(k << 2);
                bw(2'd0, cw(0, 1, m[1], m[0], 1, 0));
                wc(2);
                mxfer(m[1], m[0], mt, st);
                br(2'd1, d); chk("R5 receive full after byte", d, 8'h05);
                br(2'd2, d); chk("R4 miso byte received", d, st);
                br(2'd1, d); chk("R5 read clears receive full", d, 8'h04);
            end
        end

        // R6 gating and R7 overrun
        bw(2'd0, cw(0, 1, 0, 1, 1, 0));
        wc(2);
        mxfer(0, 1, 8'h3C, 8'hC5);
        chk("R6 no irq when receive enable clear", {7'd0, irq}, 8'h00);
        bw(2'd0, cw(1, 1, 0, 1, 1, 0));
        chk("R6 irq when receive enable set", {7'd0, irq}, 8'h01);
        mxfer(0, 1, 8'h81, 8'h7E);
        br(2'd1, d); chk("R7 overrun flagged", d, 8'h07);
        br(2'd2, d); chk("R7 newer byte kept", d, 8'h7E);
        br(2'd1, d); chk("R5 read clears both flags", d, 8'h04);
        chk("R6 irq drops after read", {7'd0, irq}, 8'h00);

        // R10 byte queued during a master transfer
        bw(2'd0, cw(0, 1, 0, 1, 1, 1));
        chk("R6 irq from tx empty enable", {7'd0, irq}, 8'h01);
        fork
            begin
                smodel(0, 1, 8'h96, c1);
                smodel(0, 1, 8'h2B, c2);
            end
            begin
                bw(2'd2, 8'hE7);
                wc(6);
                bw(2'd2, 8'h1D);
                br(2'd1, d); chk("R8 queued byte clears tx empty", d & 8'h04, 8'h00);
                chk("R10 queued byte waits", {7'd0, irq}, 8'h00);
            end
        join
        wc(6);
        chk("R10 first byte unchanged", c1, 8'hE7);
        chk("R10 queued byte sent next", c2, 8'h1D);
        br(2'd2, d); chk("R4 second received byte", d, 8'h2B);
        chk("R8 tx empty after second load", {7'd0, irq}, 8'h01);

        // R12 / R9 disabled behaviour
        bw(2'd0, cw(0, 1, 1, 0, 0, 0));
        wc(2);
        chk("R12 sck rests at idle level", {7'd0, sck_o}, 8'h01);
        chk("R12 outputs not driven", {6'd0, sck_oe, mosi_oe}, 8'h00);
        bw(2'd0, cw(0, 0, 1, 0, 0, 0));
        sck_i = 1'b1; ss_n_i = 1'b0;
        wc(6);
        chk("R12 miso not driven when disabled", {7'd0, miso_oe}, 8'h00);
        ss_n_i = 1'b1;
        bw(2'd2, 8'h77);
        br(2'd1, d); chk("R9 write while disabled dropped", d, 8'h04);
        bw(2'd0, cw(0, 1, 1, 0, 1, 0));
        wc(40);
        chk("R9 no transfer without a write", {7'd0, sck_o}, 8'h01);
        br(2'd1, d); chk("R9 nothing received", d, 8'h04);

        // R11 slave with phase 0 (idle high)
        bw(2'd0, cw(0, 0, 1, 0, 1, 0));
        bw(2'd2, 8'hB4);
        wc(4);
        ss_n_i = 1'b0;
        wc(H);
        chk("R11 miso driven before first edge", {6'd0, miso_oe, miso_o}, 8'h03);
        bw(2'd2, 8'h4A);
        br(2'd1, d); chk("R10 byte waits while slave shifts", d, 8'h00);
        mframe(1, 0, 8'hD2, c1);
        chk("R11 slave sends preloaded byte", c1, 8'hB4);
        br(2'd2, d); chk("R11 slave receives byte", d, 8'hD2);
        mframe(1, 0, 8'h55, c2);
        br(2'd1, d); chk("R11 no byte without new select", d & 8'h01, 8'h00);
        ss_n_i = 1'b1;
        wc(H);
        ss_n_i = 1'b0;
        wc(H);
        mframe(1, 0, 8'h0F, c1);
        chk("R10 waiting byte sent in next frame", c1, 8'h4A);
        br(2'd2, d); chk("R11 second framed byte", d, 8'h0F);
        ss_n_i = 1'b1;
        wc(H);

        // R13 slave with phase 1 (idle low), two bytes under one select
        sck_i = 1'b0;
        bw(2'd0, cw(0, 0, 0, 1, 1, 0));
        bw(2'd2, 8'hC3);
        wc(4);
        ss_n_i = 1'b0;
        wc(H);
        mframe(0, 1, 8'h6E, c1);
        chk("R13 first slave byte out", c1, 8'hC3);
        br(2'd2, d); chk("R13 first slave byte in", d, 8'h6E);
        bw(2'd2, 8'h39);
        mframe(0, 1, 8'hA7, c2);
        chk("R13 second byte same select", c2, 8'h39);
        br(2'd2, d); chk("R13 second slave byte in", d, 8'hA7);
        ss_n_i = 1'b1;
        wc(H);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule